// File: doc/BRIEF.md
# Four-Step Switch Handover Sequencer

This block drives the gates of one output leg of a three-input matrix-type converter. The leg reaches each input line through a bidirectional switch built from two separately gated devices. The forward device conducts output current that flows from the input line into the load. The reverse device conducts current that flows back from the load. While nothing is changing, the chosen line has both of its devices on and the other two lines are fully off.

When a different input line is requested, the block moves the leg over in four gate steps. Each step switches exactly one device, and the steps run in the order off, on, off, on. The sign of the load current, sampled when the request is taken, decides which device is switched at each step. This keeps the leg from shorting two input lines together and never leaves the load current without a path. Every step is held for a dwell count taken from an input when the request is accepted.

A request that arrives during a handover is remembered and run once the current handover ends. A request for the line already in use is dropped.

Top module: `commut4_seq`

## Requirements
- R1: While reset is asserted and after it is released, line a (code 0) is selected: gate_fwd = 3'b001, gate_rev = 3'b001, busy = 0. Bit k of each gate vector belongs to line k (a=0, b=1, c=2).
- R2: While busy is low, exactly one line has both devices on, and all devices of the other lines are off.
- R3: A request taken at clock edge E0 raises busy after E0. With D the effective dwell, busy stays high until edge E0+4D and is low after that edge.
- R4: With positive current (cur_pos = 1), the handover from old line o to new line n proceeds as follows:
  - After edge E0, only fwd[o] is on.
  - After edge E0+D, fwd[o] and fwd[n] are on.
  - After edge E0+2D, only fwd[n] is on.
  - After edge E0+3D, fwd[n] and rev[n] are on.
- R5: With negative current (cur_pos = 0), the order of R4 applies with the forward and reverse devices swapped.
- R6: Each step lasts D cycles. D equals the dwell input sampled at the accepting edge, and a dwell of 0 is treated as 1. Changes to cur_pos or dwell after that edge do not alter a running handover.
- R7: A request for the line currently selected, or for the unused code 3, is ignored: busy stays low and the gates do not change.
- R8: A request made while busy is kept; the latest one wins. It is started at the first edge after busy falls and uses cur_pos and dwell sampled at that edge. If it names the line just reached, it is dropped.
- R9: No forward device of one line is ever on together with a reverse device of a different line.
- R10: During a handover, at least one device of the conducting direction, as given by the sampled sign, is on in every cycle.
- R11: At most one of the six gate signals changes at any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New line request strobe |
| req_phase | input | 2 | Requested input line (0=a, 1=b, 2=c) |
| cur_pos | input | 1 | Load current sign, 1 = positive (into load) |
| dwell | input | DW | Cycles per step; 0 acts as 1 |
| gate_fwd | output | 3 | Forward device gate per input line |
| gate_rev | output | 3 | Reverse device gate per input line |
| busy | output | 1 | Handover in progress |

## Verification
The bench walks every step of handovers with both current signs and compares each gate pattern cycle by cycle. This catches a design that swaps the step order for negative current, which would briefly short two lines or open the load. Other tests cover:
- A dwell of zero. A design that counts it literally would stall or wrap the counter.
- Sign and dwell changes in the middle of a sequence. A design that follows the live inputs would reorder or stretch the remaining steps.
- A request made while busy. A design without a holding register would lose it.
- A request that names the line just reached. A design that does not check for it would start a pointless handover.
- Requests for the current line or for the unused code, which must leave the gates untouched.

// File: rtl/commut4_pkg.sv
package commut4_pkg;

  localparam int NLINE = 3;

  typedef logic [1:0] line_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4
  } step_e;

  // One-hot selection vector for a line code (code 3 gives no line).
  function automatic logic [NLINE-1:0] line_onehot(line_t l);
    logic [NLINE-1:0] v;
    v = '0;
    for (int k = 0; k < NLINE; k++)
      if (l == line_t'(k)) v[k] = 1'b1;
    return v;
  endfunction

  // Gate pattern {fwd, rev} held in a given step.
  // src = outgoing line, dst = incoming line, pos = sampled current sign.
  function automatic logic [2*NLINE-1:0] gate_pattern(step_e st, line_t src,
                                                       line_t dst, logic pos);
    logic [NLINE-1:0] s, d, carry, fwd, rev;
    s = line_onehot(src);
    d = line_onehot(dst);
    carry = '0;
    fwd = '0;
    rev = '0;
    case (st)
      ST_IDLE: begin fwd = s; rev = s; end
      ST_S1:   carry = s;          // idle-direction device of src is off
      ST_S2:   carry = s | d;      // conducting device of dst joins
      ST_S3:   carry = d;          // conducting device of src leaves
      ST_S4:   begin fwd = d; rev = d; end
      default: begin fwd = s; rev = s; end
    endcase
    if (st inside {ST_S1, ST_S2, ST_S3}) begin
      if (pos) fwd = carry;
      else     rev = carry;
    end
    return {fwd, rev};
  endfunction

endpackage

// File: rtl/commut4_timer.sv
module commut4_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [DW-1:0] reload_val,
  output logic          expire
);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (reload)             cnt_q <= reload_val;
    else if (cnt_q > DW'(1))     cnt_q <= cnt_q - DW'(1);
  end

  assign expire = (cnt_q <= DW'(1));

endmodule

// File: rtl/commut4_pending.sv
module commut4_pending
  import commut4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  capture,
  input  line_t cap_line,
  input  logic  clear,
  output logic  pend_valid,
  output line_t pend_line
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_line  <= '0;
    end else if (capture) begin
      pend_valid <= 1'b1;
      pend_line  <= cap_line;
    end else if (clear) begin
      pend_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/commut4_gate_map.sv
module commut4_gate_map
  import commut4_pkg::*;
(
  input  step_e            step,
  input  line_t            src,
  input  line_t            dst,
  input  logic             pos,
  output logic [NLINE-1:0] fwd,
  output logic [NLINE-1:0] rev
);

  always_comb begin
    {fwd, rev} = gate_pattern(step, src, dst, pos);
  end

endmodule

// File: rtl/commut4_seq.sv
module commut4_seq
  import commut4_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_phase,
  input  logic          cur_pos,
  input  logic [DW-1:0] dwell,
  output logic [2:0]    gate_fwd,
  output logic [2:0]    gate_rev,
  output logic          busy
);

  localparam line_t LINE_NONE = line_t'(NLINE);

  step_e         step_q;
  line_t         sel_q, tgt_q;
  logic          pos_q;
  logic [DW-1:0] dwell_q;

  logic          idle, expire, step_done, seq_end, accept_evt;
  logic          pend_valid, cand_valid, capture;
  line_t         pend_line, cand_line;
  logic [DW-1:0] dwell_eff, reload_val;
  logic          reload;

  assign idle       = (step_q == ST_IDLE);
  assign cand_valid = pend_valid | req_valid;
  assign cand_line  = pend_valid ? pend_line : line_t'(req_phase);
  assign accept_evt = idle && cand_valid && (cand_line != LINE_NONE)
                      && (cand_line != sel_q);
  assign step_done  = !idle && expire;
  assign seq_end    = step_done && (step_q == ST_S4);
  assign capture    = !idle && req_valid && (line_t'(req_phase) != LINE_NONE);

  assign dwell_eff  = (dwell == '0) ? DW'(1) : dwell;
  assign reload     = accept_evt || (step_done && !seq_end);
  assign reload_val = accept_evt ? dwell_eff : dwell_q;

  commut4_timer #(.DW(DW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (reload),
    .reload_val (reload_val),
    .expire     (expire)
  );

  commut4_pending u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .cap_line   (line_t'(req_phase)),
    .clear      (idle),
    .pend_valid (pend_valid),
    .pend_line  (pend_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= ST_IDLE;
      sel_q   <= '0;
      tgt_q   <= '0;
      pos_q   <= 1'b1;
      dwell_q <= DW'(1);
    end else if (accept_evt) begin
      step_q  <= ST_S1;
      tgt_q   <= cand_line;
      pos_q   <= cur_pos;
      dwell_q <= dwell_eff;
    end else if (seq_end) begin
      step_q  <= ST_IDLE;
      sel_q   <= tgt_q;
    end else if (step_done) begin
      case (step_q)
        ST_S1:   step_q <= ST_S2;
        ST_S2:   step_q <= ST_S3;
        default: step_q <= ST_S4;
      endcase
    end
  end

  commut4_gate_map u_map (
    .step (step_q),
    .src  (sel_q),
    .dst  (tgt_q),
    .pos  (pos_q),
    .fwd  (gate_fwd),
    .rev  (gate_rev)
  );

  assign busy = !idle;

endmodule

// File: rtl/commut4_seq_chk.sv
module commut4_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] gate_fwd,
  input logic [2:0] gate_rev,
  input logic       busy,
  input logic       held_pos
);

  // R2
  idle_one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ($countones(gate_fwd) == 1 && gate_fwd == gate_rev));

  // R9
  no_line_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_fwd[0] & (gate_rev[1] | gate_rev[2])) |
     (gate_fwd[1] & (gate_rev[0] | gate_rev[2])) |
     (gate_fwd[2] & (gate_rev[0] | gate_rev[1]))) == 1'b0);

  // R10
  path_fwd_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && held_pos) |-> (gate_fwd != 3'b000));

  // R10
  path_rev_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !held_pos) |-> (gate_rev != 3'b000));

  // R11
  single_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gate_fwd, gate_rev} ^ $past({gate_fwd, gate_rev})) <= 1);

endmodule

bind commut4_seq commut4_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_fwd (gate_fwd),
  .gate_rev (gate_rev),
  .busy     (busy),
  .held_pos (pos_q)
);

// File: tb/sim_commut4_seq.sv
module sim_commut4_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_phase = 2'd0;
  logic          cur_pos = 1'b1;
  logic [DW-1:0] dwell = 8'd1;
  logic [2:0]    gate_fwd, gate_rev;
  logic          busy;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  commut4_seq #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phase(req_phase),
    .cur_pos(cur_pos), .dwell(dwell), .gate_fwd(gate_fwd),
    .gate_rev(gate_rev), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [6:0] act,
                     input logic [6:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (busy,fwd,rev)", tag, act, exp);
    end
  endtask

  // Expected {busy, fwd, rev} for step k of a handover o->n (k=5: settled on n).
  function automatic logic [6:0] expect_at(int k, int o, int n, bit pos);
    logic [2:0] old_b, new_b, on_dir, off_dir;
    old_b = 3'b001 << o;
    new_b = 3'b001 << n;
    on_dir = 3'b000;
    off_dir = 3'b000;
    if (k == 1)      on_dir = old_b;
    else if (k == 2) on_dir = old_b | new_b;
    else if (k == 3) on_dir = new_b;
    else begin on_dir = new_b; off_dir = new_b; end
    if (k == 5) return {1'b0, new_b, new_b};
    if (pos) return {1'b1, on_dir, off_dir};
    return {1'b1, off_dir, on_dir};
  endfunction

  // Accepting edge comes next; check every cycle of the handover.
  task automatic run_steps(input int o, input int n, input bit pos,
                           input int d, input string tag, input int inj_t,
                           input logic [1:0] inj_ph, input bit flip);
    logic [6:0] e;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin cur_pos = ~cur_pos; dwell = 8'd9; end
    for (int t = 0; t <= 4*d; t++) begin
      e = (t < 4*d) ? expect_at(t/d + 1, o, n, pos) : expect_at(5, o, n, pos);
      chk({busy, gate_fwd, gate_rev} == e, tag, {busy, gate_fwd, gate_rev}, e);
      if (t == inj_t) begin req_valid = 1'b1; req_phase = inj_ph; end
      else if (inj_t >= 0 && t == inj_t + 1) req_valid = 1'b0;
      if (t < 4*d) @(negedge clk);
    end
  endtask

  task automatic request(input logic [1:0] ph);
    req_valid = 1'b1;
    req_phase = ph;
  endtask

  task automatic hold_quiet(input int cycles, input logic [2:0] line_b,
                            input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk({busy, gate_fwd, gate_rev} == {1'b0, line_b, line_b}, tag,
          {busy, gate_fwd, gate_rev}, {1'b0, line_b, line_b});
    end
  endtask

  task automatic t_reset;
    chk({busy, gate_fwd, gate_rev} == 7'b0_001_001, "R1 in reset",
        {busy, gate_fwd, gate_rev}, 7'b0_001_001);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    hold_quiet(2, 3'b001, "R1 R2 after reset");
  endtask

  task automatic t_pos_ab;   // R3 R4
    cur_pos = 1'b1; dwell = 8'd2; request(2'd1);
    run_steps(0, 1, 1'b1, 2, "R3 R4 a->b pos", -1, 2'd0, 1'b0);
  endtask

  task automatic t_neg_bc;   // R5
    cur_pos = 1'b0; dwell = 8'd3; request(2'd2);
    run_steps(1, 2, 1'b0, 3, "R5 b->c neg", -1, 2'd0, 1'b0);
  endtask

  task automatic t_zero_dwell;  // R6
    cur_pos = 1'b1; dwell = 8'd0; request(2'd0);
    run_steps(2, 0, 1'b1, 1, "R6 c->a dwell0", -1, 2'd0, 1'b0);
  endtask

  task automatic t_held_inputs;  // R6
    cur_pos = 1'b1; dwell = 8'd2; request(2'd2);
    run_steps(0, 2, 1'b1, 2, "R6 inputs held a->c", -1, 2'd0, 1'b1);
  endtask

  task automatic t_ignored;  // R7
    request(2'd2);
    hold_quiet(3, 3'b100, "R7 same line");
    request(2'd3);
    hold_quiet(3, 3'b100, "R7 code 3");
    req_valid = 1'b0;
    hold_quiet(1, 3'b100, "R7 settle");
  endtask

  task automatic t_pending;  // R8
    cur_pos = 1'b1; dwell = 8'd2; request(2'd0);
    run_steps(2, 0, 1'b1, 2, "R8 first c->a", 1, 2'd1, 1'b1);
    run_steps(0, 1, 1'b0, 9, "R8 queued a->b", -1, 2'd0, 1'b0);
  endtask

  task automatic t_pending_drop;  // R8
    cur_pos = 1'b0; dwell = 8'd1; request(2'd2);
    run_steps(1, 2, 1'b0, 1, "R8 b->c", 1, 2'd2, 1'b0);
    hold_quiet(3, 3'b100, "R8 stale queued dropped");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pos_ab();
    t_neg_bc();
    t_zero_dwell();
    t_held_inputs();
    t_ignored();
    t_pending();
    t_pending_drop();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

endmodule